// File: doc/BRIEF.md
# Byte-Bus GPIO Unit with Transceiver Direction Interlock

This block puts two 8-bit general-purpose ports on a simple byte-wide I/O bus. The bus has an address, read and write strobes, and data lines. Each port has a data register and a direction register. The direction register sets the whole port one way: every bit is an input or every bit is an output. An external bidirectional buffer sits between each port and its connector. A shared control register holds the direction bit for each buffer. That register also keeps six spare bits that belong to another function, so software can read it, modify it and write it back.

Software turns a port into an output in two steps: it sets the buffer bit first, then writes all-ones to the port direction. To turn a port back into an input, it writes all-zeros to the port direction first, then clears the buffer bit. The block drives a port's pins only when the port direction and the buffer bit both say output. In every cycle where the port is set to drive but its buffer still points inward, a contention flag is raised for that port. Pin inputs pass through a two-stage synchronizer before they can be read.

The block also stores and reads back a direction register for a reserved neighbouring port. Any write of an illegal direction value is dropped and sets a sticky error flag.

Top module: `gpio_xcvr_unit`

## Requirements
- R1: After synchronous reset: both port directions read 0x00, the buffer control register reads 0x00, both data registers hold 0x00, the reserved direction register reads 0xFF, and pin_oe, contention and dir_err are all low.
- R2: Port direction registers are at 0x98 (port index 0) and 0x99 (port index 1). They accept only 0x00 or 0xFF. Any other value written leaves the register unchanged and sets dir_err, which stays set until reset.
- R3: The buffer control register at 0x7A stores all 8 bits and reads them back unchanged. Bit 0 drives xcvr_dir[0] and bit 1 drives xcvr_dir[1]; 1 means outward.
- R4: The reserved direction register at 0x9A stores any byte written to it and reads it back.
- R5: Data registers are at 0x78 (port 0) and 0x79 (port 1). A write while the port direction is 0xFF stores the byte. The byte appears on that port's slice of pin_out, and a read of the data address returns it.
- R6: A write to a data address while the port direction is 0x00 is ignored. pin_out and the stored value stay unchanged.
- R7: A read of a data address while the port direction is 0x00 returns that port's pin_in value, taken through a two-flop synchronizer.
- R8: A port's 8 pin_oe bits are all high exactly when its direction is 0xFF and its buffer bit is 1. Otherwise they are all low.
- R9: contention[i] is high exactly when port i's direction is 0xFF and its buffer bit is 0. pin_oe for that port is low during that time.
- R10: bus_rdata is registered. It takes its value on the clock edge that samples bus_rd and holds that value until the next read. Unmapped addresses read 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Register address |
| bus_rd | input | 1 | Read strobe, one cycle |
| bus_wr | input | 1 | Write strobe, one cycle |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| pin_in | input | 16 | Connector inputs, port 0 in bits 7:0 |
| pin_out | output | 16 | Connector output values |
| pin_oe | output | 16 | Per-bit output enables |
| xcvr_dir | output | 2 | Buffer direction lines, 1 = outward |
| contention | output | 2 | Per-port drive-conflict flag |
| dir_err | output | 1 | Sticky illegal-direction-write flag |

## Verification
Each port's direction is switched in the legal order (buffer first, then port, and the reverse when going back to input). The bench then runs the illegal order, where the port is set to all-ones while its buffer still points inward. Comparing the two separates a correct interlock from one that enables the pins too early or never raises contention. Data traffic uses different bytes on the two ports and in the pin patterns. This shows whether a read is steered to the live pins or to the stored byte, and whether the two ports are wired crosswise. The bench also writes direction values that are neither 0x00 nor 0xFF, and writes every bit of the buffer register. These show whether illegal values leak into the register and whether the spare bits are kept.

// File: rtl/gpio_xcvr_pkg.sv
package gpio_xcvr_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 8;
  typedef logic [BYTE_W-1:0] byte_t;
  typedef logic [ADDR_W-1:0] addr_t;

  localparam addr_t ADDR_DATA_BASE = 8'h78;
  localparam addr_t ADDR_XCVR_CTRL = 8'h7A;
  localparam addr_t ADDR_DIR_BASE  = 8'h98;
  localparam addr_t ADDR_RSV_DIR   = 8'h9A;

  localparam byte_t RSV_DIR_RESET  = 8'hFF;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] sync_out
);
  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stage_q[0] <= '0;
    else     stage_q[0] <= async_in;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stage_q[s] <= '0;
      else     stage_q[s] <= stage_q[s-1];
    end
  end

  assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_ctrl.sv
module gpio_ctrl
  import gpio_xcvr_pkg::*;
#(
  parameter int    W         = 8,
  parameter addr_t XCVR_ADDR = ADDR_XCVR_CTRL,
  parameter addr_t RSV_ADDR  = ADDR_RSV_DIR
) (
  input  logic         clk,
  input  logic         rst,
  input  addr_t        bus_addr,
  input  logic         bus_wr,
  input  logic [W-1:0] bus_wdata,
  output logic [W-1:0] xcvr_q,
  output logic [W-1:0] rd_data,
  output logic         hit
);
  logic [W-1:0] rsv_q;
  logic         sel_xcvr, sel_rsv;

  assign sel_xcvr = (bus_addr == XCVR_ADDR);
  assign sel_rsv  = (bus_addr == RSV_ADDR);
  assign hit      = sel_xcvr | sel_rsv;

  always_ff @(posedge clk) begin
    if (rst) begin
      xcvr_q <= '0;
      rsv_q  <= W'(RSV_DIR_RESET);
    end else if (bus_wr) begin
      if (sel_xcvr) xcvr_q <= bus_wdata;
      if (sel_rsv)  rsv_q  <= bus_wdata;
    end
  end

  always_comb begin
    rd_data = '0;
    if (sel_xcvr)     rd_data = xcvr_q;
    else if (sel_rsv) rd_data = rsv_q;
  end

  // R3: the whole control byte survives a write unchanged
  a_r3_ctrl_store: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && sel_xcvr) |=> (xcvr_q == $past(bus_wdata)));
endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_xcvr_pkg::*;
#(
  parameter int    W         = 8,
  parameter addr_t DATA_ADDR = ADDR_DATA_BASE,
  parameter addr_t DIR_ADDR  = ADDR_DIR_BASE
) (
  input  logic         clk,
  input  logic         rst,
  input  addr_t        bus_addr,
  input  logic         bus_wr,
  input  logic [W-1:0] bus_wdata,
  input  logic         xcvr_bit,
  input  logic [W-1:0] pin_sync,
  output logic [W-1:0] rd_data,
  output logic         hit,
  output logic         bad_dir_wr,
  output logic [W-1:0] pin_out,
  output logic [W-1:0] pin_oe,
  output logic         contention
);
  logic [W-1:0] data_q;
  logic [W-1:0] dir_q;
  logic         sel_data, sel_dir;
  logic         port_out, dir_legal;

  assign sel_data   = (bus_addr == DATA_ADDR);
  assign sel_dir    = (bus_addr == DIR_ADDR);
  assign hit        = sel_data | sel_dir;
  assign port_out   = (dir_q == '1);
  assign dir_legal  = (bus_wdata == '0) || (bus_wdata == '1);
  assign bad_dir_wr = bus_wr && sel_dir && !dir_legal;

  always_ff @(posedge clk) begin
    if (rst) begin
      dir_q  <= '0;
      data_q <= '0;
    end else if (bus_wr) begin
      if (sel_dir && dir_legal) dir_q  <= bus_wdata;
      if (sel_data && port_out) data_q <= bus_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pin_out    <= '0;
      pin_oe     <= '0;
      contention <= 1'b0;
    end else begin
      pin_out    <= data_q;
      pin_oe     <= {W{port_out & xcvr_bit}};
      contention <= port_out & ~xcvr_bit;
    end
  end

  always_comb begin
    rd_data = '0;
    if (sel_data)     rd_data = port_out ? data_q : pin_sync;
    else if (sel_dir) rd_data = dir_q;
  end

  // R2: direction never holds anything but all-in or all-out
  a_r2_dir_legal: assert property (@(posedge clk) disable iff (rst)
    (dir_q == '0) || (dir_q == '1));

  // R6: a data write in input mode leaves the stored byte alone
  a_r6_input_write_ignored: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && sel_data && !port_out) |=> $stable(data_q));

  // R9: never enable the pins while a conflict is flagged
  a_r9_no_oe_in_conflict: assert property (@(posedge clk) disable iff (rst)
    contention |-> (pin_oe == '0));

  // R8: enable follows direction and buffer bit of the prior cycle
  a_r8_oe_qualified: assert property (@(posedge clk) disable iff (rst)
    (pin_oe != '0) |-> ($past(dir_q) == '1 && $past(xcvr_bit)));
endmodule

// File: rtl/gpio_xcvr_unit.sv
module gpio_xcvr_unit
  import gpio_xcvr_pkg::*;
#(
  parameter int NPORT = 2,
  parameter int W     = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [7:0]         bus_addr,
  input  logic               bus_rd,
  input  logic               bus_wr,
  input  logic [W-1:0]       bus_wdata,
  output logic [W-1:0]       bus_rdata,
  input  logic [NPORT*W-1:0] pin_in,
  output logic [NPORT*W-1:0] pin_out,
  output logic [NPORT*W-1:0] pin_oe,
  output logic [NPORT-1:0]   xcvr_dir,
  output logic [NPORT-1:0]   contention,
  output logic               dir_err
);
  localparam int SYNC_STAGES = 2;

  logic [W-1:0]       xcvr_q;
  logic [W-1:0]       ctrl_rd;
  logic               ctrl_hit;
  logic [NPORT*W-1:0] pin_sync;
  logic [W-1:0]       port_rd [NPORT];
  logic [NPORT-1:0]   port_hit;
  logic [NPORT-1:0]   port_bad;
  logic [W-1:0]       rd_mux;
  logic               any_hit;

  gpio_ctrl #(.W(W)) ctrl_i (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .xcvr_q(xcvr_q), .rd_data(ctrl_rd), .hit(ctrl_hit)
  );

  gpio_sync #(.W(NPORT*W), .STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst(rst), .async_in(pin_in), .sync_out(pin_sync)
  );

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    gpio_port #(
      .W(W),
      .DATA_ADDR(addr_t'(ADDR_DATA_BASE + p)),
      .DIR_ADDR(addr_t'(ADDR_DIR_BASE + p))
    ) port_i (
      .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_wdata(bus_wdata), .xcvr_bit(xcvr_q[p]),
      .pin_sync(pin_sync[p*W +: W]), .rd_data(port_rd[p]), .hit(port_hit[p]),
      .bad_dir_wr(port_bad[p]), .pin_out(pin_out[p*W +: W]),
      .pin_oe(pin_oe[p*W +: W]), .contention(contention[p])
    );
    assign xcvr_dir[p] = xcvr_q[p];
  end

  always_comb begin
    rd_mux = ctrl_rd;
    for (int p = 0; p < NPORT; p++) rd_mux = rd_mux | port_rd[p];
  end
  assign any_hit = ctrl_hit | (|port_hit);

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end

  always_ff @(posedge clk) begin
    if (rst)            dir_err <= 1'b0;
    else if (|port_bad) dir_err <= 1'b1;
  end

  // R2: error flag is sticky until reset
  a_r2_err_sticky: assert property (@(posedge clk) disable iff (rst)
    dir_err |=> dir_err);

  // R10: unmapped reads return zero one cycle later
  a_r10_unmapped_zero: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && !any_hit) |=> (bus_rdata == '0));

  // R10: read data holds between reads
  a_r10_rdata_hold: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> $stable(bus_rdata));
endmodule

// File: tb/gpio_xcvr_unit_tb_top.sv
module gpio_xcvr_unit_tb_top;
  localparam int NP = 2;
  localparam int W  = 8;

  logic          clk = 1'b0;
  logic          rst;
  logic [7:0]    bus_addr;
  logic          bus_rd, bus_wr;
  logic [W-1:0]  bus_wdata, bus_rdata;
  logic [NP*W-1:0] pin_in, pin_out, pin_oe;
  logic [NP-1:0] xcvr_dir, contention;
  logic          dir_err;

  int checks = 0;
  int errors = 0;
  logic done = 1'b0;

  always #10 clk = ~clk;

  gpio_xcvr_unit #(.NPORT(NP), .W(W)) dut_i (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_rd(bus_rd),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
    .xcvr_dir(xcvr_dir), .contention(contention), .dir_err(dir_err)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; bus_rd = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic bwrite(input logic [7:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic bread(input logic [7:0] a, output logic [7:0] d);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic expect_rd(input logic [7:0] a, input logic [7:0] exp, input string req);
    logic [7:0] d;
    bread(a, d);
    check(d === exp, req, d, exp);
  endtask

  task automatic t_reset();
    do_reset();
    expect_rd(8'h98, 8'h00, "R1 dir0");
    expect_rd(8'h99, 8'h00, "R1 dir1");
    expect_rd(8'h7A, 8'h00, "R1 ctrl");
    expect_rd(8'h9A, 8'hFF, "R1 rsv");
    check(pin_oe === '0 && contention === '0 && dir_err === 1'b0 && pin_out === '0,
          "R1 outputs", {pin_oe, contention, dir_err}, 0);
  endtask

  task automatic t_dir_legal();
    do_reset();
    bwrite(8'h98, 8'h0F);
    expect_rd(8'h98, 8'h00, "R2 illegal ignored");
    check(dir_err === 1'b1, "R2 err set", dir_err, 1);
    bwrite(8'h99, 8'hFF);
    expect_rd(8'h99, 8'hFF, "R2 legal stored");
    check(dir_err === 1'b1, "R2 err sticky", dir_err, 1);
    bwrite(8'h99, 8'h80);
    expect_rd(8'h99, 8'hFF, "R2 illegal keeps FF");
    do_reset();
    check(dir_err === 1'b0, "R2 err cleared by reset", dir_err, 0);
  endtask

  task automatic t_ctrl_rmw();
    do_reset();
    bwrite(8'h7A, 8'hA6);
    expect_rd(8'h7A, 8'hA6, "R3 full byte");
    check(xcvr_dir === 2'b10, "R3 dir lines", xcvr_dir, 2'b10);
    bwrite(8'h7A, 8'h59);
    check(xcvr_dir === 2'b01, "R3 dir lines swap", xcvr_dir, 2'b01);
  endtask

  task automatic t_rsv();
    do_reset();
    bwrite(8'h9A, 8'h3C);
    expect_rd(8'h9A, 8'h3C, "R4 reserved dir");
  endtask

  task automatic t_output_seq();
    do_reset();
    bwrite(8'h7A, 8'h01);
    check(contention === 2'b00 && pin_oe === '0, "R9 ctrl first no conflict",
          {contention, pin_oe}, 0);
    bwrite(8'h98, 8'hFF);
    check(pin_oe === 16'h00FF, "R8 oe port0", pin_oe, 16'h00FF);
    check(contention === 2'b00, "R9 legal order", contention, 0);
    bwrite(8'h78, 8'h96);
    check(pin_out[7:0] === 8'h96, "R5 pin_out", pin_out[7:0], 8'h96);
    check(pin_out[15:8] === 8'h00, "R5 other port untouched", pin_out[15:8], 0);
    expect_rd(8'h78, 8'h96, "R5 readback");
    bwrite(8'h98, 8'h00);
    check(pin_oe === '0 && contention === 2'b00, "R8 back to input",
          {contention, pin_oe}, 0);
  endtask

  task automatic t_input_ignore();
    do_reset();
    bwrite(8'h79, 8'h5A);
    check(pin_out[15:8] === 8'h00, "R6 pins unchanged", pin_out[15:8], 0);
    bwrite(8'h7A, 8'h02);
    bwrite(8'h99, 8'hFF);
    expect_rd(8'h79, 8'h00, "R6 stored byte unchanged");
    bwrite(8'h79, 8'h5A);
    expect_rd(8'h79, 8'h5A, "R5 port1 readback");
    check(pin_out[15:8] === 8'h5A && pin_oe === 16'hFF00, "R5 port1 pins",
          {pin_out[15:8], pin_oe}, {8'h5A, 16'hFF00});
  endtask

  task automatic t_pin_read();
    do_reset();
    pin_in = 16'h3CC3;
    repeat (3) @(negedge clk);
    expect_rd(8'h78, 8'hC3, "R7 port0 pins");
    expect_rd(8'h79, 8'h3C, "R7 port1 pins");
    pin_in = 16'h0000;
    @(negedge clk);
    expect_rd(8'h78, 8'hC3, "R7 two-flop latency");
    repeat (2) @(negedge clk);
    expect_rd(8'h78, 8'h00, "R7 new pins seen");
  endtask

  task automatic t_contention();
    do_reset();
    bwrite(8'h99, 8'hFF);
    check(contention === 2'b10, "R9 wrong order flagged", contention, 2'b10);
    check(pin_oe === '0, "R9 oe held low", pin_oe, 0);
    bwrite(8'h7A, 8'h02);
    check(contention === 2'b00 && pin_oe === 16'hFF00, "R8 resolved",
          {contention, pin_oe}, 16'hFF00);
    bwrite(8'h7A, 8'h00);
    check(contention === 2'b10 && pin_oe === '0, "R9 ctrl cleared early",
          {contention, pin_oe}, 2'b10);
  endtask

  task automatic t_unmapped();
    do_reset();
    expect_rd(8'h9A, 8'hFF, "R10 prior read");
    check(bus_rdata === 8'hFF, "R10 hold", bus_rdata, 8'hFF);
    repeat (2) @(negedge clk);
    check(bus_rdata === 8'hFF, "R10 hold idle", bus_rdata, 8'hFF);
    expect_rd(8'h10, 8'h00, "R10 unmapped");
  endtask

  initial begin
    rst = 1'b1; bus_rd = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    pin_in = '0;
    t_reset();
    t_dir_legal();
    t_ctrl_rmw();
    t_rsv();
    t_output_seq();
    t_input_ignore();
    t_pin_read();
    t_contention();
    t_unmapped();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule